// File: doc/BRIEF.md
# Page Flash Operation Arbiter and Status Unit

This block sits behind the command decoder of a page-organised flash with two SRAM page buffers. It does not move data. For every decoded command it decides whether the command may start, and it tracks the self-timed array operations with a busy timer. It also builds the status byte that the front end shifts out on a status read.

Six commands use the array: page-to-buffer transfer, page-to-buffer compare, buffer program with erase, buffer program without erase, program through buffer, and auto rewrite. Only one of them may run at a time. The buffer it uses is locked while it runs. The other buffer can still be read or written, and status reads always go through.

A write-protect pin guards the low pages against programming. A device reset pin aborts any running operation and holds the unit idle. Operation times are parameters counted in clock cycles, so simulation can use short values.

Top module: `flash_op_arbiter`

## Requirements
- R1: After reset, and whenever idle with no compare mismatch recorded, `status_o` is 8'hA0. Its fields are: bit 7 ready (1 = idle), bit 6 compare flag, bits 5:3 the density code 3'b100, and bits 2:0 driven 0. `busy_drv_no` is high when idle.
- R2: Command codes on `req_op_i` are: 0 transfer, 1 compare, 2 program with erase, 3 program without erase, 4 program through buffer, 5 auto rewrite, 6 buffer read, 7 buffer write, 8 status read. A granted array command keeps the unit busy for a fixed number of cycles, counted from the grant cycle:
  - codes 0 and 1: T_XFER cycles;
  - codes 2, 4 and 5: T_EP cycles;
  - code 3: T_P cycles.
- R3: A request is sampled on a rising edge. `grant_o` or `reject_o` is high for the single cycle that follows. For a granted array command, `busy_drv_no` goes low and status bit 7 goes to 0 in that same cycle.
- R4: An array command requested while busy is rejected, including a request on the last busy cycle. The rejection leaves the running operation, its timing and `status_o` unchanged.
- R5: While busy, the unit grants these requests:
  - buffer reads and writes to the buffer not selected by the running operation (`req_buf_i` 0 or 1);
  - status reads.
  It rejects reads and writes to the locked buffer.
- R6: When a compare finishes, bit 6 takes `cmp_diff_i` (0 = match, 1 = mismatch). Bit 6 keeps that value through all other commands until the next compare finishes.
- R7: With `wp_ni` low, the unit rejects codes 2, 3, 4 and 5 to any page below PROT_PAGES (256). Transfer and compare to such pages are still granted. With `wp_ni` high, programming them is granted.
- R8: While `dev_rst_ni` is low, every request is rejected. From the next cycle any running operation is abandoned: the unit reports ready, and an aborted compare leaves bit 6 unchanged.
- R9: `grant_o` and `reject_o` are never high together and are both low in cycles that follow no request. An undefined command code is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_rst_ni | input | 1 | Device reset pin, active low, abort and hold idle |
| wp_ni | input | 1 | Write protect, active low |
| req_valid_i | input | 1 | Command request strobe |
| req_op_i | input | 4 | Command code |
| req_buf_i | input | 1 | Buffer select |
| req_page_i | input | PAGE_W | Target page |
| cmp_diff_i | input | 1 | Compare result from data path, 1 = mismatch |
| status_o | output | 8 | Status byte |
| busy_drv_no | output | 1 | Active-low enable of the open-drain busy driver |
| grant_o | output | 1 | Request accepted (one cycle) |
| reject_o | output | 1 | Request refused (one cycle) |

## Verification
Two events can fall on the same edge: a running compare finishes, and a new array request arrives. The bench tracks the grant cycle with its own cycle counter. It lines the next program request up exactly on the final busy edge and expects a rejection. In the cycle that follows, it expects the compare flag to be updated and the unit to be ready. The same program request is then re-issued and must be granted with the program-only duration. A second overlap drops the device reset during a compare with a mismatch on `cmp_diff_i`, and the bench checks that bit 6 keeps its old value.

// File: rtl/fop_pkg.sv
package fop_pkg;
  typedef enum logic [3:0] {
    OP_XFER    = 4'd0,
    OP_CMP     = 4'd1,
    OP_PGM_ERS = 4'd2,
    OP_PGM     = 4'd3,
    OP_PGM_BUF = 4'd4,
    OP_REWRITE = 4'd5,
    OP_BUF_RD  = 4'd6,
    OP_BUF_WR  = 4'd7,
    OP_STAT    = 4'd8
  } op_e;

  localparam logic [2:0] DENSITY_CODE = 3'b100;

  function automatic logic op_is_array(op_e o);
    return o inside {OP_XFER, OP_CMP, OP_PGM_ERS, OP_PGM, OP_PGM_BUF, OP_REWRITE};
  endfunction

  function automatic logic op_is_prog(op_e o);
    return o inside {OP_PGM_ERS, OP_PGM, OP_PGM_BUF, OP_REWRITE};
  endfunction

  function automatic logic op_is_buf(op_e o);
    return o inside {OP_BUF_RD, OP_BUF_WR};
  endfunction
endpackage

// File: rtl/fop_guard.sv
module fop_guard
  import fop_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PROT_PAGES = 256
) (
  input  logic              req_valid_i,
  input  op_e               req_op_i,
  input  logic              req_buf_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic              wp_ni,
  input  logic              dev_rst_ni,
  input  logic              busy_i,
  input  logic              act_buf_i,
  output logic              grant_o,
  output logic              reject_o,
  output logic              start_o
);
  localparam logic [PAGE_W-1:0] PROT_LIM = PAGE_W'(PROT_PAGES);

  logic protected_hit;
  assign protected_hit = op_is_prog(req_op_i) && !wp_ni && (req_page_i < PROT_LIM);

  always_comb begin
    grant_o  = 1'b0;
    reject_o = 1'b0;
    if (req_valid_i) begin
      if (!dev_rst_ni) begin
        reject_o = 1'b1;
      end else if (op_is_array(req_op_i)) begin
        if (busy_i || protected_hit) reject_o = 1'b1;
        else                         grant_o  = 1'b1;
      end else if (op_is_buf(req_op_i)) begin
        // only the buffer owned by the running array op is locked
        if (busy_i && (req_buf_i == act_buf_i)) reject_o = 1'b1;
        else                                    grant_o  = 1'b1;
      end else if (req_op_i == OP_STAT) begin
        grant_o = 1'b1;
      end else begin
        reject_o = 1'b1;
      end
    end
  end

  assign start_o = grant_o && op_is_array(req_op_i);
endmodule

// File: rtl/fop_timer.sv
module fop_timer
  import fop_pkg::*;
#(
  parameter int T_XFER = 12,
  parameter int T_EP   = 40,
  parameter int T_P    = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  input  op_e  op_i,
  input  logic buf_i,
  output logic busy_o,
  output logic act_buf_o,
  output logic cmp_fin_o
);
  localparam int T_MAX1 = (T_EP > T_P) ? T_EP : T_P;
  localparam int T_MAX  = (T_MAX1 > T_XFER) ? T_MAX1 : T_XFER;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] D_XFER = CNT_W'(T_XFER);
  localparam logic [CNT_W-1:0] D_EP   = CNT_W'(T_EP);
  localparam logic [CNT_W-1:0] D_P    = CNT_W'(T_P);

  logic [CNT_W-1:0] cnt_q, dur;
  op_e              act_op_q;
  logic             act_buf_q;

  always_comb begin
    unique case (op_i)
      OP_XFER, OP_CMP: dur = D_XFER;
      OP_PGM:          dur = D_P;
      default:         dur = D_EP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_op_q  <= OP_XFER;
      act_buf_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q     <= dur;
      act_op_q  <= op_i;
      act_buf_q <= buf_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign act_buf_o = act_buf_q;
  assign cmp_fin_o = (cnt_q == CNT_W'(1)) && !abort_i && (act_op_q == OP_CMP);
endmodule

// File: rtl/fop_status.sv
module fop_status
  import fop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       cmp_fin_i,
  input  logic       cmp_diff_i,
  output logic [7:0] status_o
);
  logic cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cmp_q <= 1'b0;
    else if (cmp_fin_i) cmp_q <= cmp_diff_i;
  end

  assign status_o = {~busy_i, cmp_q, DENSITY_CODE, 3'b000};
endmodule

// File: rtl/flash_op_arbiter.sv
module flash_op_arbiter
  import fop_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PROT_PAGES = 256,
  parameter int T_XFER     = 12,
  parameter int T_EP       = 40,
  parameter int T_P        = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_ni,
  input  logic              wp_ni,
  input  logic              req_valid_i,
  input  logic [3:0]        req_op_i,
  input  logic              req_buf_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic              cmp_diff_i,
  output logic [7:0]        status_o,
  output logic              busy_drv_no,
  output logic              grant_o,
  output logic              reject_o
);
  op_e  op;
  logic busy, act_buf, cmp_fin;
  logic grant_d, reject_d, start;
  logic grant_q, reject_q;

  assign op = op_e'(req_op_i);

  fop_guard #(.PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES)) u_guard (
    .req_valid_i (req_valid_i),
    .req_op_i    (op),
    .req_buf_i   (req_buf_i),
    .req_page_i  (req_page_i),
    .wp_ni       (wp_ni),
    .dev_rst_ni  (dev_rst_ni),
    .busy_i      (busy),
    .act_buf_i   (act_buf),
    .grant_o     (grant_d),
    .reject_o    (reject_d),
    .start_o     (start)
  );

  fop_timer #(.T_XFER(T_XFER), .T_EP(T_EP), .T_P(T_P)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (~dev_rst_ni),
    .start_i   (start),
    .op_i      (op),
    .buf_i     (req_buf_i),
    .busy_o    (busy),
    .act_buf_o (act_buf),
    .cmp_fin_o (cmp_fin)
  );

  fop_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .cmp_fin_i  (cmp_fin),
    .cmp_diff_i (cmp_diff_i),
    .status_o   (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= grant_d;
      reject_q <= reject_d;
    end
  end

  assign grant_o     = grant_q;
  assign reject_o    = reject_q;
  assign busy_drv_no = ~busy;
endmodule

// File: rtl/flash_op_arbiter_chk.sv
module flash_op_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dev_rst_ni,
  input logic [7:0] status_o,
  input logic       busy_drv_no,
  input logic       grant_o,
  input logic       reject_o
);
  assert_grant_xor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o));

  assert_density_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:0] == 6'b100000);

  assert_busy_with_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_drv_no) |-> grant_o);

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_rst_ni |=> busy_drv_no);

  assert_cmp_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && $past(status_o[7])) |-> $stable(status_o[6]));
endmodule

bind flash_op_arbiter flash_op_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_rst_ni  (dev_rst_ni),
  .status_o    (status_o),
  .busy_drv_no (busy_drv_no),
  .grant_o     (grant_o),
  .reject_o    (reject_o)
);

// File: tb/flash_op_arbiter_tb.sv
`timescale 1ns/1ps
module flash_op_arbiter_tb;
  localparam int T_XFER = 12;
  localparam int T_EP   = 40;
  localparam int T_P    = 28;

  localparam logic [3:0] C_XFER = 4'd0, C_CMP = 4'd1, C_PGM_ERS = 4'd2, C_PGM = 4'd3,
                         C_PGM_BUF = 4'd4, C_REWRITE = 4'd5, C_BUF_RD = 4'd6,
                         C_BUF_WR = 4'd7, C_STAT = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst_n = 1'b1;
  logic        wp_n = 1'b1;
  logic        req_v = 1'b0;
  logic [3:0]  req_op = '0;
  logic        req_buf = 1'b0;
  logic [11:0] req_page = '0;
  logic        cmp_diff = 1'b0;
  logic [7:0]  status;
  logic        busy_n, grant, reject;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int g = 0;
  bit finished = 1'b0;

  typedef struct { logic g; logic r; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  flash_op_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_ni(dev_rst_n), .wp_ni(wp_n),
    .req_valid_i(req_v), .req_op_i(req_op), .req_buf_i(req_buf),
    .req_page_i(req_page), .cmp_diff_i(cmp_diff),
    .status_o(status), .busy_drv_no(busy_n), .grant_o(grant), .reject_o(reject)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per sampled request
  logic mon_v;
  always @(posedge clk) begin
    mon_v = req_v;
    #2;
    if (mon_v) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 no expectation", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(grant === e.g && reject === e.r, e.tag, {grant, reject}, {e.g, e.r});
      end
    end else if (rst_n && (grant !== 1'b0 || reject !== 1'b0)) begin
      chk(1'b0, "R9 response without request", {grant, reject}, 0);
    end
  end

  task automatic req(input logic [3:0] op, input logic b, input int page,
                     input logic eg, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    req_v = 1'b1; req_op = op; req_buf = b; req_page = 12'(page);
    e.g = eg; e.r = er; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    req_v = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_n === 1'b0 && n < 1000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(status === 8'hA0, "R1 reset status", status, 8'hA0);
    chk(busy_n === 1'b1, "R1 reset busy pin", busy_n, 1);

    // transfer with overlapping buffer and status traffic
    req(C_XFER, 1'b0, 5, 1, 0, "R3 transfer grant");
    g = cyc;
    chk(busy_n === 1'b0, "R3 busy with grant", busy_n, 0);
    chk(status === 8'h20, "R3 status busy", status, 8'h20);
    req(C_BUF_RD, 1'b1, 0, 1, 0, "R5 other buffer read");
    req(C_BUF_WR, 1'b0, 0, 0, 1, "R5 locked buffer write");
    req(C_STAT, 1'b0, 0, 1, 0, "R5 status read while busy");
    req(C_CMP, 1'b1, 9, 0, 1, "R4 second array op");
    chk(status === 8'h20 && busy_n === 1'b0, "R4 reject keeps state", status, 8'h20);
    wait_idle();
    chk(cyc - g == T_XFER, "R2 transfer length", cyc - g, T_XFER);

    // compare mismatch, then sticky across a transfer
    cmp_diff = 1'b1;
    req(C_CMP, 1'b1, 7, 1, 0, "R6 compare grant");
    g = cyc;
    wait_idle();
    chk(cyc - g == T_XFER, "R2 compare length", cyc - g, T_XFER);
    chk(status === 8'hE0, "R6 mismatch flag", status, 8'hE0);
    cmp_diff = 1'b0;
    req(C_XFER, 1'b1, 7, 1, 0, "R6 transfer grant");
    wait_idle();
    chk(status === 8'hE0, "R6 flag sticky", status, 8'hE0);

    // compare finishing on the same edge as a new array request
    req(C_CMP, 1'b0, 3, 1, 0, "R6 compare match grant");
    g = cyc;
    while (cyc < g + T_XFER - 1) begin @(posedge clk); #1; end
    req(C_PGM, 1'b0, 300, 0, 1, "R4 request on last busy cycle");
    chk(busy_n === 1'b1 && status === 8'hA0, "R6 match flag at end", status, 8'hA0);
    req(C_PGM, 1'b0, 300, 1, 0, "R4 retry granted");
    g = cyc;
    wait_idle();
    chk(cyc - g == T_P, "R2 program length", cyc - g, T_P);

    req(C_PGM_ERS, 1'b1, 20, 1, 0, "R2 erase program grant");
    g = cyc; wait_idle();
    chk(cyc - g == T_EP, "R2 erase program length", cyc - g, T_EP);
    req(C_PGM_BUF, 1'b0, 21, 1, 0, "R2 program through buffer grant");
    g = cyc; wait_idle();
    chk(cyc - g == T_EP, "R2 program through buffer length", cyc - g, T_EP);
    req(C_REWRITE, 1'b1, 22, 1, 0, "R2 rewrite grant");
    g = cyc;
    req(C_BUF_RD, 1'b1, 0, 0, 1, "R5 locked buffer read");
    req(C_BUF_WR, 1'b0, 0, 1, 0, "R5 other buffer write");
    wait_idle();
    chk(cyc - g == T_EP, "R2 rewrite length", cyc - g, T_EP);

    // write protect
    wp_n = 1'b0;
    req(C_PGM_ERS, 1'b0, 255, 0, 1, "R7 protected erase program");
    chk(busy_n === 1'b1 && status === 8'hA0, "R7 refused stays idle", status, 8'hA0);
    req(C_REWRITE, 1'b0, 0, 0, 1, "R7 protected rewrite");
    req(C_PGM_BUF, 1'b1, 255, 0, 1, "R7 protected program through buffer");
    req(C_PGM, 1'b1, 100, 0, 1, "R7 protected program");
    req(C_XFER, 1'b0, 0, 1, 0, "R7 transfer allowed");
    wait_idle();
    req(C_PGM, 1'b0, 256, 1, 0, "R7 unprotected page");
    wait_idle();
    wp_n = 1'b1;
    req(C_PGM_ERS, 1'b0, 10, 1, 0, "R7 protect released");
    wait_idle();

    // device reset abort
    req(C_PGM_ERS, 1'b0, 40, 1, 0, "R8 program before abort");
    repeat (3) @(posedge clk);
    @(negedge clk); dev_rst_n = 1'b0;
    @(posedge clk); #1;
    chk(busy_n === 1'b1 && status === 8'hA0, "R8 abort releases busy", status, 8'hA0);
    req(C_STAT, 1'b0, 0, 0, 1, "R8 status refused in reset");
    req(C_XFER, 1'b0, 0, 0, 1, "R8 array refused in reset");
    @(negedge clk); dev_rst_n = 1'b1;
    cmp_diff = 1'b1;
    req(C_CMP, 1'b0, 1, 1, 0, "R8 compare before abort");
    @(negedge clk); dev_rst_n = 1'b0;
    @(negedge clk); dev_rst_n = 1'b1;
    @(posedge clk); #1;
    chk(status === 8'hA0, "R8 aborted compare keeps flag", status, 8'hA0);
    cmp_diff = 1'b0;
    req(C_XFER, 1'b0, 1, 1, 0, "R8 grant after release");
    wait_idle();

    req(4'hF, 1'b0, 0, 0, 1, "R9 undefined code");
    repeat (3) @(posedge clk);
    #3;
    chk(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule